// File: doc/BRIEF.md
# Dual-Mode Serial Shift-Latch Port

This block is the serial loading port of a sixteen-channel LED driver. It shifts one bit from a serial data line into a long shift chain each time the serial shift enable is high at a clock edge. The first bit shifted in ends up in the most significant position of a frame. A mode input selects how the frame is used. In correction mode, the low 96 bits of the chain form sixteen 6-bit channel words. In grayscale mode, all 192 bits form sixteen 12-bit channel words. In both modes channel 15 sits in the top bits.

A latch strobe copies the chain into the holding register that the mode picks while the strobe is high. The holding register tracks the chain for as long as the strobe stays high. The serial output shows the bit at the end of the active chain: bit 95 in correction mode and bit 191 in grayscale mode. This lets several ports be chained by feeding one output into the next input.

When a grayscale latch ends, a status word is loaded into the chain. The sixteen fault flags sit in its upper bits and every other bit is zero. The controller reads the status back during the next input frame.

Top module: `led_serial_port`

## Requirements
- R1: After reset both holding registers and the serial output are zero.
- R2: After 192 shifts and a grayscale latch, gs_data[191] holds the first bit shifted and gs_data[0] the last.
- R3: After a correction latch, dc_data holds the last 96 bits shifted, the first of them in dc_data[95]; channel 15 is dc_data[95:90].
- R4: Mode is sampled while the strobe is high. Mode 1 writes only dc_data and mode 0 writes only gs_data; the other register keeps its value.
- R5: While the strobe is high, the selected holding register takes the chain contents at every clock edge, so shifts made during the strobe reach it one cycle later.
- R6: The serial output equals chain bit 191 when mode is 0 and chain bit 95 when mode is 1, giving a delay of 192 or 96 shifts.
- R7: At the first edge with the strobe low after a strobe in which mode was 0, the chain loads {fault_in, 176 zero bits}. Over the next 192 shifts, sout presents fault_in[15] first, then the remaining flags, then zeros.
- R8: The end of a strobe in which mode was 1 leaves the chain unchanged.
- R9: With shift enable low the chain keeps its contents, whatever the serial input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 1 selects correction frames, 0 selects grayscale frames |
| sin | input | 1 | Serial data in |
| shift_en | input | 1 | Shift one bit at this edge |
| latch | input | 1 | Level-sensitive latch strobe |
| fault_in | input | 16 | Per-channel fault flags for the status word |
| sout | output | 1 | Serial data out, end of the active chain |
| dc_data | output | 96 | Correction holding register, 6 bits per channel |
| gs_data | output | 192 | Grayscale holding register, 12 bits per channel |

## Verification
The input patterns are chosen so that each one separates a specific fault. Three frames with distinct, asymmetric bit patterns are used, so that a reversed bit order, a wrong frame offset or the wrong target register each produce a visibly different result. The serial output is compared bit by bit in three situations: during a grayscale frame that follows a status load, during a correction frame that follows a correction latch, and after a shift-free pause. Together these tell apart the 96-bit and 192-bit tap points, a status load from a missing one, and a held chain from a leaking one. Finally, a strobe held for two cycles while shifting shows whether the holding register tracks the chain or keeps only its first copy.

// File: rtl/led_serial_port.sv
module led_serial_port #(
  parameter int CHANNELS = 16,
  parameter int DC_W     = 6,
  parameter int GS_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode,
  input  logic                     sin,
  input  logic                     shift_en,
  input  logic                     latch,
  input  logic [CHANNELS-1:0]      fault_in,
  output logic                     sout,
  output logic [CHANNELS*DC_W-1:0] dc_data,
  output logic [CHANNELS*GS_W-1:0] gs_data
);
  localparam int DC_LEN = CHANNELS * DC_W;
  localparam int GS_LEN = CHANNELS * GS_W;
  localparam int PAD    = GS_LEN - CHANNELS;

  logic [GS_LEN-1:0] sr;
  logic              latch_q;
  logic              mode_q;
  logic              load_status;

  assign load_status = latch_q && !latch && !mode_q;
  assign sout        = mode ? sr[DC_LEN-1] : sr[GS_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      latch_q <= latch;
      if (latch) mode_q <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr <= '0;
    else if (load_status)
      sr <= {fault_in, {PAD{1'b0}}};
    else if (shift_en)
      sr <= {sr[GS_LEN-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_data <= '0;
      gs_data <= '0;
    end else if (latch) begin
      if (mode) dc_data <= sr[DC_LEN-1:0];
      else      gs_data <= sr;
    end
  end
endmodule

module led_serial_port_chk #(
  parameter int CHANNELS = 16,
  parameter int DC_LEN   = 96,
  parameter int GS_LEN   = 192
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode,
  input logic                shift_en,
  input logic                latch,
  input logic [CHANNELS-1:0] fault_in,
  input logic [DC_LEN-1:0]   dc_data,
  input logic [GS_LEN-1:0]   gs_data,
  input logic [GS_LEN-1:0]   chain
);
  logic prev_latch, prev_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_latch <= 1'b0;
      prev_mode  <= 1'b0;
    end else begin
      prev_latch <= latch;
      if (latch) prev_mode <= mode;
    end
  end

  a_r4_dc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch && mode) |=> $stable(dc_data));
  a_r4_gs_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch && !mode) |=> $stable(gs_data));
  a_r5_gs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !mode) |=> gs_data == $past(chain));
  a_r7_status_top: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_latch && !latch && !prev_mode) |=> chain[GS_LEN-1 -: CHANNELS] == $past(fault_in));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !(prev_latch && !latch)) |=> $stable(chain));
endmodule

bind led_serial_port led_serial_port_chk #(
  .CHANNELS(CHANNELS), .DC_LEN(DC_LEN), .GS_LEN(GS_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .shift_en(shift_en), .latch(latch),
  .fault_in(fault_in), .dc_data(dc_data), .gs_data(gs_data), .chain(sr)
);

// File: tb/led_serial_port_test.sv
module led_serial_port_test;
  logic clk = 0, rst_n = 0, mode = 0, sin = 0, shift_en = 0, latch = 0;
  logic [15:0]  fault = 16'hA5C3;
  logic         sout;
  logic [95:0]  dc_data;
  logic [191:0] gs_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  led_serial_port uut (.clk(clk), .rst_n(rst_n), .mode(mode), .sin(sin),
    .shift_en(shift_en), .latch(latch), .fault_in(fault), .sout(sout),
    .dc_data(dc_data), .gs_data(gs_data));

  logic [191:0] sr_m = '0, gs_m = '0;
  logic [95:0]  dc_m = '0;
  logic [191:0] q_val[$];
  int           q_sel[$];
  string        q_tag[$];

  task automatic expect_item(input int sel, input logic [191:0] v, input string tag);
    q_val.push_back(v); q_sel.push_back(sel); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    #1;
    while (q_val.size() > 0) begin
      logic [191:0] v, act;
      int s;
      string t;
      v = q_val.pop_front(); s = q_sel.pop_front(); t = q_tag.pop_front();
      act = (s == 0) ? gs_data : (s == 1) ? {96'b0, dc_data} : {191'b0, sout};
      checks++;
      if (act !== v) begin
        errors++;
        $display("FAIL %s sel%0d actual %h expected %h", t, s, act, v);
      end
    end
  end

  task automatic shift_frame(input logic [191:0] f, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      expect_item(2, {191'b0, (mode ? sr_m[95] : sr_m[191])}, tag);
      sin = f[i]; shift_en = 1;
      @(negedge clk);
      sr_m = {sr_m[190:0], f[i]};
    end
    shift_en = 0;
  endtask

  task automatic do_latch(input logic m);
    mode = m; latch = 1;
    @(negedge clk);
    if (m) dc_m = sr_m[95:0]; else gs_m = sr_m;
    latch = 0;
    @(negedge clk);
    if (!m) sr_m = {fault, 176'b0};
  endtask

  localparam logic [191:0] FA = {6{32'hC3A5_0F96}};
  localparam logic [191:0] FB = {6{32'h5AF0_3C69}} ^ {32'h1234_5678, 160'b0};
  localparam logic [191:0] FC = {96'b0, 96'hF1E2_D3C4_B5A6_9788_7069_5A4B};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_item(0, '0, "R1"); expect_item(1, '0, "R1"); expect_item(2, '0, "R1");
    @(negedge clk);

    mode = 0;
    shift_frame(FA, 192, "R6");
    do_latch(0);
    expect_item(0, FA, "R2");
    expect_item(1, '0, "R4");
    expect_item(2, {191'b0, fault[15]}, "R7");
    @(negedge clk);

    mode = 0;
    shift_frame(FB, 192, "R7");
    do_latch(1);
    expect_item(1, {96'b0, FB[95:0]}, "R3");
    expect_item(0, FA, "R4");
    expect_item(2, {191'b0, FB[95]}, "R8");
    @(negedge clk);

    shift_frame(FC, 96, "R8");
    do_latch(1);
    expect_item(1, {96'b0, FC[95:0]}, "R3");
    expect_item(1, {96'b0, dc_m[95:90], dc_m[89:0]}, "R3");
    if (FC[95:90] !== 6'b111100) begin errors++; $display("FAIL R3 bench frame"); end
    expect_item(0, FA, "R4");
    @(negedge clk);

    mode = 0;
    for (int k = 0; k < 10; k++) begin sin = k[0]; @(negedge clk); end
    expect_item(2, {191'b0, sr_m[191]}, "R9");
    @(negedge clk);
    do_latch(0);
    expect_item(0, gs_m, "R9");
    @(negedge clk);

    mode = 0; latch = 1; sin = 1; shift_en = 1;
    @(negedge clk);
    gs_m = sr_m; sr_m = {sr_m[190:0], 1'b1};
    expect_item(0, gs_m, "R5");
    shift_en = 0;
    @(negedge clk);
    gs_m = sr_m;
    expect_item(0, gs_m, "R5");
    latch = 0;
    @(negedge clk);
    sr_m = {fault, 176'b0};
    expect_item(2, {191'b0, fault[15]}, "R7");
    @(negedge clk);
    shift_frame(FA, 20, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule